// File: doc/BRIEF.md
# Asynchronous Write Strobe Capture Filter

This block sits between an external asynchronous memory-style bus and logic that runs on a system clock. It watches active-low chip-select, write-strobe and read-strobe lines, plus a low-supply flag, and turns each legitimate write on that bus into a single clocked event. The event is a one-cycle valid pulse together with the write address and the write data.

Every input is retimed through two flip-flops before any decision is made. The address and data buses go through the same two-stage path as the strobes, so a bus sample stays aligned with the strobe sample taken at the same clock edge. The write window is the time during which both chip-select and write-strobe are low. The address is taken when the window opens, which is when the later of the two strobes falls. The data is taken when the window closes, which is when the earlier of the two strobes rises.

A window is discarded if it lasts fewer than `MIN_LOW` system clocks. It is also discarded if the read strobe is low, or the supply flag is raised, at its start or at any point while it is open. Interpreting the command carried by the write is left to the logic downstream.

Top module: `wr_capture_filter`

## Requirements
- R1: The reported address is the address bus value present when the later of chip-select and write-strobe went low. Address changes made later in the same window do not affect it.
- R2: The reported data is the data bus value present when the earlier of chip-select and write-strobe went high. Data values held earlier in the window do not affect it.
- R3: Each accepted write raises `wr_valid` for exactly one clock cycle, after the window has closed. `wr_addr` and `wr_data` are valid in that cycle.
- R4: A window in which both strobes are low for fewer than `MIN_LOW` consecutive clocks produces no pulse. A window of exactly `MIN_LOW` clocks produces one pulse.
- R5: A window that opens while the read strobe is low produces no pulse, even if the read strobe rises before the window closes.
- R6: If the read strobe goes low at any time while a window is open, that window produces no pulse.
- R7: If `supply_low` is high at any time while a window is open, that window produces no pulse.
- R8: A write-strobe low pulse while chip-select stays high, or a chip-select low pulse while write-strobe stays high, produces no pulse.
- R9: While reset is asserted and right after reset, `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros.
- R10: After a window has been rejected, the next clean window is accepted and reports its own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| cs_n_in | input | 1 | Asynchronous chip-select, active low |
| wstb_n_in | input | 1 | Asynchronous write strobe, active low |
| rstb_n_in | input | 1 | Asynchronous read strobe, active low; blocks writes while low |
| supply_low | input | 1 | Asynchronous low-supply flag; blocks writes while high |
| addr_in | input | AW | Asynchronous address bus |
| data_in | input | DW | Asynchronous data bus |
| wr_valid | output | 1 | One-cycle pulse for each accepted write |
| wr_addr | output | AW | Address captured when the window opened |
| wr_data | output | DW | Data captured when the window closed |

## Verification
The hardest case to reach is a window in which the address bus and the data bus each take several values, while the two strobes fall and rise at different times. Only this case separates "latched when the later strobe falls" from "latched when the earlier strobe rises". The bench builds it explicitly. It drops chip-select first and changes the address before dropping write-strobe. It changes the data partway through the window, and releases write-strobe a few clocks before chip-select while changing the data in between. Each bus value is held across the two-flop retiming latency, so the expected values follow from the requirements alone.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
  typedef enum logic {
    WCF_IDLE = 1'b0,
    WCF_OPEN = 1'b1
  } wcf_state_e;
endpackage

// File: rtl/wcf_sync2.sv
// Two-stage retiming register for asynchronous inputs.
module wcf_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/wcf_tracker.sv
// Tracks one write window: open edge, length count, inhibit abort, close.
module wcf_tracker
  import wcf_pkg::*;
#(
  parameter int MIN_LOW = 4,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          window,
  input  logic          inhibit,
  output logic          start,
  output logic          accept,
  output logic          open,
  output logic          abort,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);
  localparam logic [CW-1:0] ONE   = CW'(1);

  wcf_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          abort_q, abort_d;
  logic          win_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    abort_d = abort_q;
    start   = 1'b0;
    accept  = 1'b0;
    case (state_q)
      WCF_IDLE: begin
        if (window && !win_q && !inhibit) begin
          state_d = WCF_OPEN;
          cnt_d   = ONE;
          abort_d = 1'b0;
          start   = 1'b1;
        end
      end
      WCF_OPEN: begin
        if (window) begin
          if (cnt_q < LIMIT) cnt_d = cnt_q + ONE;
          if (inhibit) abort_d = 1'b1;
        end else begin
          state_d = WCF_IDLE;
          accept  = !abort_q && (cnt_q >= LIMIT);
        end
      end
      default: state_d = WCF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WCF_IDLE;
      cnt_q   <= '0;
      abort_q <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      abort_q <= abort_d;
      win_q   <= window;
    end
  end

  assign open  = (state_q == WCF_OPEN);
  assign abort = abort_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/wr_capture_filter.sv
// Turns asynchronous write strobes into one-cycle clocked write events.
module wr_capture_filter #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int MIN_LOW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_in,
  input  logic          wstb_n_in,
  input  logic          rstb_n_in,
  input  logic          supply_low,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam int NCTL  = 4;

  logic [NCTL-1:0] ctl_raw, ctl_s;
  logic [AW-1:0]   addr_s;
  logic [DW-1:0]   data_s;
  logic            cs_n_s, wstb_n_s, rstb_n_s, low_s;
  logic            window, inhibit;
  logic            trk_start, trk_accept, trk_open, trk_abort;
  logic [CNT_W-1:0] trk_cnt;

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  assign ctl_raw = {supply_low, rstb_n_in, wstb_n_in, cs_n_in};

  wcf_sync2 #(.W(NCTL), .RST_VAL(4'b0111)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );
  wcf_sync2 #(.W(AW), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr_in), .q(addr_s)
  );
  wcf_sync2 #(.W(DW), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(data_in), .q(data_s)
  );

  assign cs_n_s   = ctl_s[0];
  assign wstb_n_s = ctl_s[1];
  assign rstb_n_s = ctl_s[2];
  assign low_s    = ctl_s[3];

  assign window  = !cs_n_s && !wstb_n_s;
  assign inhibit = !rstb_n_s || low_s;

  wcf_tracker #(.MIN_LOW(MIN_LOW), .CW(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .window(window), .inhibit(inhibit),
    .start(trk_start), .accept(trk_accept), .open(trk_open),
    .abort(trk_abort), .cnt(trk_cnt)
  );

  always_comb begin
    valid_d = trk_accept;
    addr_d  = trk_start  ? addr_s : addr_q;
    data_d  = trk_accept ? data_s : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/wcf_checker.sv
module wcf_checker #(
  parameter int AW      = 16,
  parameter int MIN_LOW = 4,
  parameter int CW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          open,
  input logic          window,
  input logic          abort,
  input logic [CW-1:0] cnt
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R3
  AST_PULSE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(open) && !$past(window))); // R3
  AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(cnt) >= CW'(MIN_LOW))); // R4
  AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(abort)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (open && $past(open)) |-> $stable(wr_addr)); // R1
endmodule

bind wr_capture_filter wcf_checker #(.AW(AW), .MIN_LOW(MIN_LOW), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .open(trk_open), .window(window), .abort(trk_abort), .cnt(trk_cnt)
);

// File: tb/tb_wr_capture_filter.sv
`timescale 1ns/1ps
module tb_wr_capture_filter;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MIN_LOW = 4;

  logic clk, rst_n;
  logic cs_n, wstb_n, rstb_n, slow;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks, errors, vcount, wide_err;
  logic prev_v;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;

  wr_capture_filter #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .wstb_n_in(wstb_n),
    .rstb_n_in(rstb_n), .supply_low(slow), .addr_in(addr), .data_in(data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) prev_v = 1'b0;
    else begin
      if (wr_valid) begin
        vcount++;
        last_a = wr_addr;
        last_d = wr_data;
        if (prev_v) wide_err++;
      end
      prev_v = wr_valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    addr = a; data = d; cs_n = 1'b0; wstb_n = 1'b0;
    cyc(len);
    cs_n = 1'b1; wstb_n = 1'b1;
    cyc(6);
  endtask

  task automatic expect_write(input string req, input int base,
                              input logic [AW-1:0] a, input logic [DW-1:0] d);
    check(vcount == base + 1, req, vcount - base, 1);
    check(last_a == a, req, last_a, a);
    check(last_d == d, req, last_d, d);
  endtask

  task automatic t_reset;
    check(wr_valid == 1'b0, "R9 valid", wr_valid, 0);
    check(wr_addr == '0, "R9 addr", wr_addr, 0);
    check(wr_data == '0, "R9 data", wr_data, 0);
  endtask

  task automatic t_basic;
    int b;
    b = vcount; pulse(16'h1234, 8'hA5, 6); expect_write("R3 basic1", b, 16'h1234, 8'hA5);
    b = vcount; pulse(16'hFFFF, 8'h00, 9); expect_write("R3 basic2", b, 16'hFFFF, 8'h00);
    b = vcount; pulse(16'h0000, 8'hFF, 5); expect_write("R3 basic3", b, 16'h0000, 8'hFF);
  endtask

  task automatic t_later_fall;
    int b;
    b = vcount;
    @(negedge clk);
    addr = 16'h0A0A; data = 8'h11; cs_n = 1'b0;
    cyc(3);
    addr = 16'h5B5B;
    cyc(1);
    wstb_n = 1'b0;
    cyc(3);
    addr = 16'hDEAD;
    cyc(4);
    cs_n = 1'b1; wstb_n = 1'b1;
    cyc(6);
    expect_write("R1 later fall", b, 16'h5B5B, 8'h11);
  endtask

  task automatic t_earlier_rise;
    int b;
    b = vcount;
    @(negedge clk);
    addr = 16'h2222; data = 8'h01; cs_n = 1'b0; wstb_n = 1'b0;
    cyc(3);
    data = 8'h3C;
    cyc(4);
    wstb_n = 1'b1;
    cyc(2);
    data = 8'hC3;
    cyc(2);
    cs_n = 1'b1;
    cyc(6);
    expect_write("R2 earlier rise", b, 16'h2222, 8'h3C);
  endtask

  task automatic t_threshold;
    int b;
    b = vcount; pulse(16'h4444, 8'h44, MIN_LOW - 1);
    check(vcount == b, "R4 short", vcount - b, 0);
    b = vcount; pulse(16'h4545, 8'h45, 1);
    check(vcount == b, "R4 one clock", vcount - b, 0);
    b = vcount; pulse(16'h4646, 8'h46, MIN_LOW);
    expect_write("R4 exact", b, 16'h4646, 8'h46);
  endtask

  task automatic t_rstb_at_open;
    int b;
    b = vcount;
    @(negedge clk);
    rstb_n = 1'b0; addr = 16'h5555; data = 8'h55; cs_n = 1'b0; wstb_n = 1'b0;
    cyc(2);
    rstb_n = 1'b1;
    cyc(8);
    cs_n = 1'b1; wstb_n = 1'b1;
    cyc(6);
    check(vcount == b, "R5 read strobe at open", vcount - b, 0);
    b = vcount; pulse(16'h5656, 8'h56, 6);
    expect_write("R10 after R5", b, 16'h5656, 8'h56);
  endtask

  task automatic t_rstb_mid;
    int b;
    b = vcount;
    @(negedge clk);
    addr = 16'h6666; data = 8'h66; cs_n = 1'b0; wstb_n = 1'b0;
    cyc(4);
    rstb_n = 1'b0;
    cyc(2);
    rstb_n = 1'b1;
    cyc(4);
    cs_n = 1'b1; wstb_n = 1'b1;
    cyc(6);
    check(vcount == b, "R6 read strobe mid", vcount - b, 0);
  endtask

  task automatic t_supply;
    int b;
    b = vcount;
    @(negedge clk);
    addr = 16'h7777; data = 8'h77; cs_n = 1'b0; wstb_n = 1'b0;
    cyc(3);
    slow = 1'b1;
    cyc(2);
    slow = 1'b0;
    cyc(4);
    cs_n = 1'b1; wstb_n = 1'b1;
    cyc(6);
    check(vcount == b, "R7 supply low", vcount - b, 0);
    b = vcount; pulse(16'h7878, 8'h78, 6);
    expect_write("R10 after R7", b, 16'h7878, 8'h78);
  endtask

  task automatic t_single;
    int b;
    b = vcount;
    @(negedge clk); addr = 16'h8888; data = 8'h88; wstb_n = 1'b0;
    cyc(8); wstb_n = 1'b1; cyc(6);
    check(vcount == b, "R8 write strobe only", vcount - b, 0);
    @(negedge clk); cs_n = 1'b0;
    cyc(8); cs_n = 1'b1; cyc(6);
    check(vcount == b, "R8 chip select only", vcount - b, 0);
    check(last_a == 16'h7878, "R8 addr untouched", last_a, 16'h7878);
  endtask

  initial begin
    checks = 0; errors = 0; vcount = 0; wide_err = 0; prev_v = 1'b0;
    last_a = '0; last_d = '0;
    rst_n = 1'b0; cs_n = 1'b1; wstb_n = 1'b1; rstb_n = 1'b1; slow = 1'b0;
    addr = '0; data = '0;
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(3);
    t_reset;
    t_basic;
    t_later_fall;
    t_earlier_rise;
    t_threshold;
    t_rstb_at_open;
    t_rstb_mid;
    t_supply;
    t_single;
    check(wide_err == 0, "R3 pulse width", wide_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule